// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a set of binary lock tokens that two independent requesters, a left side and a right side, use to claim shared resources without a race. Each side has its own select, write enable, output enable, address and byte-wide data buses. The low address bits choose one of the tokens. A write carrying zero in data bit 0 asks for the token, and a write carrying one gives it back. A read returns the token state as that side sees it, copied onto every data bit. Zero means the reading side holds the token.

Every token keeps one request latch per side and a single owner bit. A request that arrives while the other side holds the token is kept. The token passes to that side as soon as the holder releases it, with no retry needed. When both sides ask for a free token in the same clock cycle, the left side gets it and the right request stays pending. The read result is taken at the start of a read and does not change until the read ends. This gives software a stable value to test.

Top module: `sem_bank`

## Requirements
- R1: After reset every token is free, and a read of any index from either side returns 8'hFF.
- R2: A write with data bit 0 = 0 to a free token makes that token read 8'h00 from the writing side and 8'hFF from the other side.
- R3: A write with data bit 0 = 0 from the side that does not hold the token is recorded as pending. That side keeps reading 8'hFF while the holder keeps the token.
- R4: When the holder writes data bit 0 = 1 while the other side has a pending request, the other side holds the token from the next cycle (reads 8'h00) and the former holder reads 8'hFF.
- R5: When the holder writes data bit 0 = 1 with nothing pending, the token becomes free and both sides read 8'hFF.
- R6: Write data bits 7..1 have no effect. Only data bit 0 selects request (0) or release (1).
- R7: Only address bits 2..0 choose the token. Higher address bits have no effect on writes or reads.
- R8: A read is active while sel=1, oe=1 and we=0. The data appears on rdata in the cycle after the first active cycle, as all eight bits equal to the flag. rdata is 8'h00 in every cycle after one in which no read is active.
- R9: rdata keeps the value taken at the start of a read for as long as the read stays active, even when the token changes meanwhile.
- R10: If both sides write data bit 0 = 0 to the same free token in the same cycle, the left side gets it and the right request stays pending.
- R11: For each token, at most one side sees it as held (flag 0) at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| l_sel | input | 1 | Left semaphore select |
| l_we | input | 1 | Left write enable (1 = write) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | AW (6) | Left address; bits 2..0 pick the token |
| l_wdata | input | DW (8) | Left write data; bit 0 used |
| l_rdata | output | DW (8) | Left read data |
| r_sel | input | 1 | Right semaphore select |
| r_we | input | 1 | Right write enable (1 = write) |
| r_oe | input | 1 | Right output enable |
| r_addr | input | AW (6) | Right address; bits 2..0 pick the token |
| r_wdata | input | DW (8) | Right write data; bit 0 used |
| r_rdata | output | DW (8) | Right read data |

## Verification
A wrong request latch or owner bit does not show at the ports until a side reads that token. The bench therefore reads both sides often and checks rdata in every cycle against a model built from the requirements. A lost pending request shows as 8'hFF where 8'h00 is expected, on the first read after the release. A token that both sides think they hold, or a read value that changes during a read, is reported at the clock edge where it happens.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic {
    OWN_LEFT  = 1'b0,
    OWN_RIGHT = 1'b1
  } owner_e;
endpackage

// File: rtl/sem_rst_sync.sv
module sem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int AW   = 6,
  parameter int DW   = 8,
  parameter int IDXW = 3
) (
  input  logic            sel,
  input  logic            we,
  input  logic            oe,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic            wr,
  output logic            rd,
  output logic            wbit,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    wr   = sel & we;
    rd   = sel & oe & ~we;
    wbit = wdata[0];
    idx  = addr[IDXW-1:0];
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_wr,
  input  logic l_val,
  input  logic r_wr,
  input  logic r_val,
  output logic l_flag,
  output logic r_flag
);
  logic   req_l_q, req_r_q, req_l_d, req_r_d;
  owner_e own_q, own_d;
  logic   held_now, held_next, upd_en;

  always_comb begin
    req_l_d   = l_wr ? l_val : req_l_q;
    req_r_d   = r_wr ? r_val : req_r_q;
    held_now  = (own_q == OWN_LEFT) ? ~req_l_q : ~req_r_q;
    held_next = (own_q == OWN_LEFT) ? ~req_l_d : ~req_r_d;
    own_d     = own_q;
    if (!(held_now && held_next)) begin
      if (!req_l_d)      own_d = OWN_LEFT;
      else if (!req_r_d) own_d = OWN_RIGHT;
    end
    upd_en = l_wr | r_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_l_q <= 1'b1;
      req_r_q <= 1'b1;
      own_q   <= OWN_LEFT;
    end else if (upd_en) begin
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
      own_q   <= own_d;
    end
  end

  assign l_flag = ~(~req_l_q && (own_q == OWN_LEFT));
  assign r_flag = ~(~req_r_q && (own_q == OWN_RIGHT));
endmodule

// File: rtl/sem_rd_capture.sv
module sem_rd_capture #(
  parameter int NSEM = 8,
  parameter int DW   = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd,
  input  logic [IDXW-1:0] idx,
  input  logic [NSEM-1:0] flags,
  output logic [DW-1:0]   rdata
);
  logic          rd_q;
  logic [DW-1:0] data_q, data_d;
  logic          cap_en;

  always_comb begin
    cap_en = rd & ~rd_q;
    data_d = {DW{flags[idx]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (cap_en) data_q <= data_d;
  end

  assign rdata = rd_q ? data_q : '0;
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NSEM = 8,
  parameter int AW   = 6,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sel,
  input  logic          l_we,
  input  logic          l_oe,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          r_sel,
  input  logic          r_we,
  input  logic          r_oe,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata
);
  localparam int IDXW = $clog2(NSEM);

  logic            rst_sync_n;
  logic            l_wr, l_rd, l_wbit, r_wr, r_rd, r_wbit;
  logic [IDXW-1:0] l_idx, r_idx;
  logic [NSEM-1:0] flag_l, flag_r;

  sem_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sem_port_dec #(.AW(AW), .DW(DW), .IDXW(IDXW)) u_dec_l (
    .sel(l_sel), .we(l_we), .oe(l_oe), .addr(l_addr), .wdata(l_wdata),
    .wr(l_wr), .rd(l_rd), .wbit(l_wbit), .idx(l_idx)
  );

  sem_port_dec #(.AW(AW), .DW(DW), .IDXW(IDXW)) u_dec_r (
    .sel(r_sel), .we(r_we), .oe(r_oe), .addr(r_addr), .wdata(r_wdata),
    .wr(r_wr), .rd(r_rd), .wbit(r_wbit), .idx(r_idx)
  );

  for (genvar g = 0; g < NSEM; g++) begin : g_cell
    sem_cell u_cell (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .l_wr  (l_wr && (l_idx == IDXW'(g))),
      .l_val (l_wbit),
      .r_wr  (r_wr && (r_idx == IDXW'(g))),
      .r_val (r_wbit),
      .l_flag(flag_l[g]),
      .r_flag(flag_r[g])
    );
  end

  sem_rd_capture #(.NSEM(NSEM), .DW(DW), .IDXW(IDXW)) u_cap_l (
    .clk(clk), .rst_n(rst_sync_n), .rd(l_rd), .idx(l_idx),
    .flags(flag_l), .rdata(l_rdata)
  );

  sem_rd_capture #(.NSEM(NSEM), .DW(DW), .IDXW(IDXW)) u_cap_r (
    .clk(clk), .rst_n(rst_sync_n), .rd(r_rd), .idx(r_idx),
    .flags(flag_r), .rdata(r_rdata)
  );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int NSEM = 8,
  parameter int AW   = 6,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            l_sel,
  input logic            l_we,
  input logic            l_oe,
  input logic [AW-1:0]   l_addr,
  input logic [DW-1:0]   l_wdata,
  input logic [DW-1:0]   l_rdata,
  input logic            r_sel,
  input logic            r_we,
  input logic            r_oe,
  input logic [AW-1:0]   r_addr,
  input logic [DW-1:0]   r_wdata,
  input logic [DW-1:0]   r_rdata,
  input logic [NSEM-1:0] flag_l,
  input logic [NSEM-1:0] flag_r
);
  localparam int IDXW = $clog2(NSEM);

  logic [IDXW-1:0] li, ri;
  logic            lw0, rw0, lrd, rrd;
  assign li  = l_addr[IDXW-1:0];
  assign ri  = r_addr[IDXW-1:0];
  assign lw0 = l_sel && l_we && !l_wdata[0];
  assign rw0 = r_sel && r_we && !r_wdata[0];
  assign lrd = l_sel && l_oe && !l_we;
  assign rrd = r_sel && r_oe && !r_we;

  // R11
  no_dual_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    &(flag_l | flag_r));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lrd |=> (l_rdata == '0));

  // R8
  replicate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_rdata == '0) || (r_rdata == '1));

  // R9
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rrd && $past(rrd)) |=> $stable(r_rdata));

  // R2
  left_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lw0 && flag_l[li] && flag_r[li]) |=> !flag_l[$past(li)]);

  // R10
  tie_left_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lw0 && rw0 && (li == ri) && flag_l[li] && flag_r[li])
      |=> (!flag_l[$past(li)] && flag_r[$past(li)]));

  // R3
  pending_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rw0 && !flag_l[ri] && !(l_sel && l_we && (li == ri)))
      |=> flag_r[$past(ri)]);
endmodule

bind sem_bank sem_bank_chk #(.NSEM(NSEM), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .l_sel(l_sel), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr),
  .l_wdata(l_wdata), .l_rdata(l_rdata),
  .r_sel(r_sel), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr),
  .r_wdata(r_wdata), .r_rdata(r_rdata),
  .flag_l(flag_l), .flag_r(flag_r)
);

// File: tb/sim_sem_bank.sv
module sim_sem_bank;
  localparam int NSEM = 8;
  localparam int AW   = 6;
  localparam int DW   = 8;

  logic          clk;
  logic          rst_n;
  logic          l_sel, l_we, l_oe, r_sel, r_we, r_oe;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

  sem_bank #(.NSEM(NSEM), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int nchk;
  int nfail;
  bit done;

  // expected state: request latches (0 = requesting) and owner (0 = left)
  bit          req_l[NSEM];
  bit          req_r[NSEM];
  bit          own[NSEM];
  bit          pl_rd, pr_rd;
  logic [DW-1:0] exp_l, exp_r;

  function automatic bit fl(int i);
    return !(!req_l[i] && !own[i]);
  endfunction

  function automatic bit fr(int i);
    return !(!req_r[i] && own[i]);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NSEM; i++) begin
      req_l[i] = 1'b1; req_r[i] = 1'b1; own[i] = 1'b0;
    end
    pl_rd = 1'b0; pr_rd = 1'b0; exp_l = '0; exp_r = '0;
  endtask

  task automatic setl(bit s, bit w, bit o, logic [AW-1:0] a, logic [DW-1:0] d);
    l_sel = s; l_we = w; l_oe = o; l_addr = a; l_wdata = d;
  endtask

  task automatic setr(bit s, bit w, bit o, logic [AW-1:0] a, logic [DW-1:0] d);
    r_sel = s; r_we = w; r_oe = o; r_addr = a; r_wdata = d;
  endtask

  task automatic idle();
    setl(0, 0, 0, '0, '0);
    setr(0, 0, 0, '0, '0);
  endtask

  task automatic check(string tag, string side, logic [DW-1:0] act, logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s rdata actual=%h expected=%h", tag, side, act, exp);
    end
  endtask

  // one clock: update the expected state from the driven inputs, then compare
  task automatic step(string tag);
    bit lrd, rrd, lw, rw, keep_now, keep_next;
    int li, ri;
    bit nl[NSEM];
    bit nr[NSEM];
    @(posedge clk);
    li  = int'(l_addr[2:0]);
    ri  = int'(r_addr[2:0]);
    lrd = l_sel && l_oe && !l_we;
    rrd = r_sel && r_oe && !r_we;
    lw  = l_sel && l_we;
    rw  = r_sel && r_we;
    if (lrd && !pl_rd) exp_l = {DW{fl(li)}};
    else if (!lrd)     exp_l = '0;
    if (rrd && !pr_rd) exp_r = {DW{fr(ri)}};
    else if (!rrd)     exp_r = '0;
    pl_rd = lrd; pr_rd = rrd;
    for (int i = 0; i < NSEM; i++) begin
      nl[i] = (lw && li == i) ? l_wdata[0] : req_l[i];
      nr[i] = (rw && ri == i) ? r_wdata[0] : req_r[i];
      keep_now  = own[i] ? !req_r[i] : !req_l[i];
      keep_next = own[i] ? !nr[i] : !nl[i];
      if (!(keep_now && keep_next)) begin
        if (!nl[i])      own[i] = 1'b0;
        else if (!nr[i]) own[i] = 1'b1;
      end
      req_l[i] = nl[i]; req_r[i] = nr[i];
    end
    @(negedge clk);
    check(tag, "left", l_rdata, exp_l);
    check(tag, "right", r_rdata, exp_r);
  endtask

  // read one index on both sides (one active cycle), then one idle cycle
  task automatic read_both(string tag, logic [AW-1:0] la, logic [AW-1:0] ra,
                           logic [DW-1:0] el, logic [DW-1:0] er);
    setl(1, 0, 1, la, '0);
    setr(1, 0, 1, ra, '0);
    step(tag);
    check(tag, "left direct", l_rdata, el);
    check(tag, "right direct", r_rdata, er);
    idle();
    step(tag);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    nchk = 0; nfail = 0; done = 1'b0;
    void'($urandom(32'h1d5e_a9c3));
    idle();
    model_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "left idle", l_rdata, 8'h00);

    // R1: everything free after reset
    for (int i = 0; i < NSEM; i++)
      read_both("R1", AW'(i), AW'(i), 8'hFF, 8'hFF);

    // R2: left takes free token 2
    setl(1, 1, 0, 6'd2, 8'h00); step("R2"); idle(); step("R2");
    read_both("R2", 6'd2, 6'd2, 8'h00, 8'hFF);

    // R3: right request waits
    setr(1, 1, 0, 6'd2, 8'h00); step("R3"); idle(); step("R3");
    read_both("R3", 6'd2, 6'd2, 8'h00, 8'hFF);

    // R4: release hands over to pending right
    setl(1, 1, 0, 6'd2, 8'h01); step("R4"); idle(); step("R4");
    read_both("R4", 6'd2, 6'd2, 8'hFF, 8'h00);

    // R5: release with nothing pending frees it
    setr(1, 1, 0, 6'd2, 8'h01); step("R5"); idle(); step("R5");
    read_both("R5", 6'd2, 6'd2, 8'hFF, 8'hFF);

    // R6: upper data bits ignored
    setl(1, 1, 0, 6'd3, 8'hFE); step("R6"); idle(); step("R6");
    read_both("R6", 6'd3, 6'd3, 8'h00, 8'hFF);
    setl(1, 1, 0, 6'd3, 8'h01); step("R6"); idle(); step("R6");
    read_both("R6", 6'd3, 6'd3, 8'hFF, 8'hFF);

    // R7: high address bits ignored
    setl(1, 1, 0, 6'b101_011, 8'h00); step("R7"); idle(); step("R7");
    read_both("R7", 6'b111_011, 6'b010_011, 8'h00, 8'hFF);
    setl(1, 1, 0, 6'b110_011, 8'h01); step("R7"); idle(); step("R7");

    // R9: right owns 5, left pending, left read held across the hand-over
    setr(1, 1, 0, 6'd5, 8'h00); step("R9");
    setr(0, 0, 0, '0, '0); setl(1, 1, 0, 6'd5, 8'h00); step("R9");
    setl(1, 0, 1, 6'd5, '0); idle(); setl(1, 0, 1, 6'd5, '0); step("R9");
    check("R9", "left start", l_rdata, 8'hFF);
    setr(1, 1, 0, 6'd5, 8'h01); step("R9");
    setr(0, 0, 0, '0, '0);
    for (int k = 0; k < 3; k++) begin
      step("R9");
      check("R9", "left frozen", l_rdata, 8'hFF);
    end
    idle(); step("R8");
    check("R8", "left after read", l_rdata, 8'h00);
    read_both("R9", 6'd5, 6'd5, 8'h00, 8'hFF);
    setl(1, 1, 0, 6'd5, 8'h01); step("R9"); idle(); step("R9");

    // R10: simultaneous requests, left wins, right pending
    setl(1, 1, 0, 6'd6, 8'h00); setr(1, 1, 0, 6'd6, 8'h00); step("R10");
    idle(); step("R10");
    read_both("R10", 6'd6, 6'd6, 8'h00, 8'hFF);
    setl(1, 1, 0, 6'd6, 8'h01); step("R10"); idle(); step("R10");
    read_both("R10", 6'd6, 6'd6, 8'hFF, 8'h00);

    // R11: random mix, every cycle compared with the expected state
    for (int n = 0; n < 3000; n++) begin
      int lop, rop;
      lop = $urandom_range(0, 2);
      rop = $urandom_range(0, 2);
      setl(lop != 0, lop == 1, $urandom_range(0, 1) == 1 || lop == 2,
           AW'($urandom), DW'($urandom));
      setr(rop != 0, rop == 1, $urandom_range(0, 1) == 1 || rop == 2,
           AW'($urandom), DW'($urandom));
      step("R11");
    end
    idle(); step("R8");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule